// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block tracks the coherence state of every line in one processor's private write-back cache that sits on a shared single bus. Tags and two-bit states are held in a direct-mapped array indexed by the low address bits. Processor reads and writes that can be served locally finish in the cycle they are presented. All others raise a bus request, and the block holds the processor through `cpu_ready` until the bus grants the transaction. A dirty victim is written back first, then the line is filled or upgraded.

A second copy of the tag and state array serves the snoop port. Transactions issued by other caches are looked up there in the same cycle they appear, so snooping never competes with processor lookups. The snoop port reports a shared copy on reads and asks for dirty data to be supplied when a Modified line is hit. A read miss ends in Exclusive when no other cache reports a copy, which lets a later write complete without touching the bus.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_ready`, `bus_req`, `snp_shared` and `snp_supply` are low while no request is present, and a snooped read reports no copy.
- R2: The state encoding is Invalid=0, Shared=1, Exclusive=2, Modified=3. The bus command encoding is read=0, read-for-ownership=1, invalidate=2, write-back=3. A read miss with `bus_shared` low at grant issues a bus read of `cpu_addr` and leaves the line Exclusive, and `cpu_state` shows 2.
- R3: A read miss with `bus_shared` high at grant leaves the line Shared (`cpu_state`=1).
- R4: A write to an Invalid line issues read-for-ownership. A write to a Shared line issues invalidate. Both end in Modified.
- R5: A write to an Exclusive line completes in the cycle it is presented, with no bus request, and ends in Modified.
- R6: Reads that hit Shared, Exclusive or Modified lines, and writes that hit Modified lines, complete in the cycle they are presented with no bus request and no change of state.
- R7: A snooped read that hits a Modified line raises `snp_supply` and `snp_shared` in that cycle, and the line becomes Shared.
- R8: A snooped read-for-ownership or invalidate that hits a Modified line raises `snp_supply` in that cycle, and the line becomes Invalid.
- R9: A snooped read that hits Exclusive makes the line Shared. A snooped read-for-ownership or invalidate that hits Shared or Exclusive makes it Invalid. A snooped write-back, or a snoop whose tag does not match, changes nothing.
- R10: `snp_shared` is high in the cycle of a snooped read that hits a valid line, and only for snooped reads.
- R11: A miss whose victim line is Modified first issues a write-back of the victim's address, then the fill. A clean victim is dropped with no write-back.
- R12: While a bus transaction is pending, `cpu_ready` stays low and `bus_req`, `bus_cmd` and `bus_addr` hold steady until `bus_gnt`. The request completes in the grant cycle.
- R13: A locally served request is held off for any cycle in which a snoop targets the same index, and it completes in the next free cycle. A snoop to another index does not delay it.
- R14: `cpu_ready` is only raised while `cpu_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_state | output | 2 | Line state after the completing request |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | Command of the requested transaction |
| bus_addr | output | ADDR_W | Address of the requested transaction |
| bus_gnt | input | 1 | Requested transaction is placed on the bus this cycle |
| bus_shared | input | 1 | Another cache holds the line (valid at grant) |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_shared | output | 1 | This cache holds a copy of the snooped line |
| snp_supply | output | 1 | This cache supplies or flushes dirty data |

## Verification
The properties assume a single-bus world. `bus_gnt` is raised only while `bus_req` is high, and never in a cycle that also carries `snp_valid`. The processor holds `cpu_req`, `cpu_we` and `cpu_addr` unchanged until `cpu_ready`. The stimulus keeps to this. A responder grants only a pending request, after a fixed wait. Snoops are issued only while no bus transaction is pending, except where a snoop is deliberately placed beside a locally served hit. Each operation holds its request until completion.

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [1:0]        cpu_state,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPG = 2'd2, CMD_WB = 2'd3;

  logic [TAG_W-1:0] ctag_q [LINES];
  logic [1:0]       cst_q  [LINES];
  logic [TAG_W-1:0] stag_q [LINES];
  logic [1:0]       sst_q  [LINES];

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire             c_match = (ctag_q[c_idx] == c_tag);
  wire [1:0]       c_st = c_match ? cst_q[c_idx] : ST_I;
  wire             victim_dirty = !c_match && (cst_q[c_idx] == ST_M);
  wire             hit_ok = cpu_we ? (c_st == ST_E || c_st == ST_M) : (c_st != ST_I);

  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];
  wire [1:0]       s_st = (stag_q[s_idx] == s_tag) ? sst_q[s_idx] : ST_I;
  wire             snp_same = snp_valid && (s_idx == c_idx);

  assign bus_req  = cpu_req && !hit_ok;
  assign bus_cmd  = victim_dirty ? CMD_WB :
                    !cpu_we      ? CMD_RD :
                    (c_st == ST_S) ? CMD_UPG : CMD_RDX;
  assign bus_addr = victim_dirty ? {ctag_q[c_idx], c_idx} : cpu_addr;

  wire hit_done  = cpu_req && hit_ok && !snp_same;
  wire fill_done = bus_req && bus_gnt && !victim_dirty;
  wire wb_done   = bus_req && bus_gnt && victim_dirty;

  assign cpu_ready = hit_done || fill_done;
  assign cpu_state = hit_done  ? (cpu_we ? ST_M : c_st) :
                     fill_done ? (cpu_we ? ST_M : (bus_shared ? ST_S : ST_E)) : ST_I;

  wire             c_wr     = hit_done || fill_done || wb_done;
  wire [TAG_W-1:0] c_wr_tag = fill_done ? c_tag : ctag_q[c_idx];
  wire [1:0]       c_wr_st  = wb_done ? ST_I : cpu_state;

  assign snp_shared = snp_valid && (snp_cmd == CMD_RD) && (s_st != ST_I);
  assign snp_supply = snp_valid && (snp_cmd != CMD_WB) && (s_st == ST_M);

  wire       s_wr   = snp_valid && (snp_cmd != CMD_WB) && (s_st != ST_I);
  wire [1:0] s_next = (snp_cmd == CMD_RD) ? ST_S : ST_I;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        ctag_q[i] <= '0;
        stag_q[i] <= '0;
        cst_q[i]  <= ST_I;
        sst_q[i]  <= ST_I;
      end
    end else begin
      if (c_wr) begin
        ctag_q[c_idx] <= c_wr_tag;
        stag_q[c_idx] <= c_wr_tag;
        cst_q[c_idx]  <= c_wr_st;
        sst_q[c_idx]  <= c_wr_st;
      end
      if (s_wr) begin
        cst_q[s_idx] <= s_next;
        sst_q[s_idx] <= s_next;
      end
    end
  end
endmodule

module mesi_snoop_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic [1:0]        cpu_state,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              bus_shared,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_shared,
  input logic              snp_supply
);
  localparam logic [1:0] ST_M = 2'd3;
  localparam logic [1:0] CMD_RD = 2'd0, CMD_WB = 2'd3;

  a_r14_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  a_r12_ready_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && bus_req) |-> bus_gnt);

  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid && !cpu_ready) |=>
      (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  a_r11_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == CMD_WB) |=> (bus_req && bus_cmd != CMD_WB));

  a_r4_write_ends_modified: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> (cpu_state == ST_M));

  a_r10_shared_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> (snp_valid && snp_cmd == CMD_RD));

  a_r8_supply_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_valid && snp_cmd != CMD_WB));

  a_r13_snoop_blocks_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !bus_gnt) |-> !(snp_valid && snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]));
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/mesi_snoop_ctrl_tb_top.sv
`timescale 1ns/100ps
module mesi_snoop_ctrl_tb_top;
  localparam logic [1:0] I = 0, S = 1, E = 2, M = 3;
  localparam logic [1:0] RD = 0, RDX = 1, UPG = 2, WB = 3;
  localparam logic [15:0] A = 16'h0013, B = 16'h0023, C = 16'h0015;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [15:0] cpu_addr = 0;
  logic cpu_ready;
  logic [1:0] cpu_state;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [15:0] bus_addr;
  logic bus_gnt = 0, bus_shared = 0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [15:0] snp_addr = 0;
  logic snp_shared, snp_supply;

  int checks = 0, errors = 0, wcnt = 0;
  logic [19:0] exp_q[$];
  string exp_r[$];

  always #2.5 clk = ~clk;

  mesi_snoop_ctrl dut_i (.*);

  task automatic fail(string rq, string what, logic [19:0] act, logic [19:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
  endtask

  task automatic pop_cmp(logic [19:0] act);
    checks++;
    if (exp_q.size() == 0) fail("-", "unexpected event", act, 20'h0);
    else begin
      logic [19:0] e = exp_q.pop_front();
      string r = exp_r.pop_front();
      if (act !== e) fail(r, "event", act, e);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (bus_req && bus_gnt) pop_cmp({2'd1, bus_cmd, bus_addr});
    if (cpu_ready) pop_cmp({2'd2, cpu_state, cpu_addr});
  end

  initial forever begin
    @(posedge clk); #2;
    if (bus_gnt) begin bus_gnt = 0; wcnt = 0; end
    else if (bus_req) begin
      if (wcnt == 2) bus_gnt = 1; else wcnt++;
    end
  end

  task automatic exp_bus(logic [1:0] c, logic [15:0] a, string rq);
    exp_q.push_back({2'd1, c, a}); exp_r.push_back(rq);
  endtask

  task automatic exp_rdy(logic [1:0] st, logic [15:0] a, string rq);
    exp_q.push_back({2'd2, st, a}); exp_r.push_back(rq);
  endtask

  task automatic cpu_op(logic we, logic [15:0] a, logic sh, bit fast, string rq);
    int n = 0;
    bus_shared = sh;
    @(posedge clk); #1 cpu_req = 1; cpu_we = we; cpu_addr = a;
    @(negedge clk);
    while (!cpu_ready) begin n++; @(negedge clk); end
    checks++;
    if (fast != (n == 0)) fail(rq, "wait cycles", 20'(n), fast ? 20'd0 : 20'd1);
    @(posedge clk); #1 cpu_req = 0;
  endtask

  task automatic snoop(logic [1:0] c, logic [15:0] a, logic esh, logic esup, string rq);
    @(posedge clk); #1 snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    checks++;
    if (snp_shared !== esh || snp_supply !== esup)
      fail(rq, "snoop shared/supply", {18'd0, snp_shared, snp_supply}, {18'd0, esh, esup});
    @(posedge clk); #1 snp_valid = 0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({cpu_ready, bus_req, snp_shared, snp_supply} !== 4'b0)
      fail("R1", "reset outputs", {16'd0, cpu_ready, bus_req, snp_shared, snp_supply}, 20'd0);
    @(posedge clk); #1 rst_n = 1;
    snoop(RD, A, 0, 0, "R1 invalid after reset");

    exp_bus(RD, A, "R2"); exp_rdy(E, A, "R2");
    cpu_op(0, A, 0, 0, "R12 stall until grant");
    exp_rdy(E, A, "R6"); cpu_op(0, A, 0, 1, "R6 read hit E");
    exp_rdy(M, A, "R5"); cpu_op(1, A, 0, 1, "R5 write E silent");
    exp_rdy(M, A, "R6"); cpu_op(1, A, 0, 1, "R6 write hit M");
    exp_rdy(M, A, "R6"); cpu_op(0, A, 0, 1, "R6 read hit M");
    snoop(RD, A, 1, 1, "R7 read hits M");
    snoop(RD, A, 1, 0, "R7 now shared R10");
    exp_rdy(S, A, "R6"); cpu_op(0, A, 0, 1, "R6 read hit S");
    exp_bus(UPG, A, "R4"); exp_rdy(M, A, "R4");
    cpu_op(1, A, 0, 0, "R4 write S upgrade");
    snoop(RDX, A, 0, 1, "R8 rfo hits M");
    snoop(RD, A, 0, 0, "R8 now invalid");
    exp_bus(RD, A, "R3"); exp_rdy(S, A, "R3");
    cpu_op(0, A, 1, 0, "R3 read miss shared");
    snoop(UPG, A, 0, 0, "R9 invalidate hits S");
    snoop(RD, A, 0, 0, "R9 now invalid");
    exp_bus(RDX, A, "R4"); exp_rdy(M, A, "R4");
    cpu_op(1, A, 0, 0, "R4 write miss rfo");
    snoop(WB, A, 0, 0, "R9 write-back ignored");
    snoop(RD, B, 0, 0, "R9 tag mismatch ignored");
    snoop(UPG, A, 0, 1, "R8 invalidate hits M");
    exp_bus(RDX, A, "R4"); exp_rdy(M, A, "R4");
    cpu_op(1, A, 0, 0, "R4 refill M");
    exp_bus(WB, A, "R11"); exp_bus(RD, B, "R11"); exp_rdy(E, B, "R11");
    cpu_op(0, B, 0, 0, "R11 dirty eviction");
    exp_bus(RD, A, "R11"); exp_rdy(E, A, "R11");
    cpu_op(0, A, 0, 0, "R11 clean eviction");
    snoop(RD, A, 1, 0, "R9 read hits E R10");
    exp_rdy(S, A, "R9"); cpu_op(0, A, 0, 1, "R9 E became S");
    snoop(RDX, A, 0, 0, "R9 rfo hits S");
    exp_bus(RD, A, "R2"); exp_rdy(E, A, "R2");
    cpu_op(0, A, 0, 0, "R2 refill exclusive");
    exp_bus(RD, C, "R2"); exp_rdy(E, C, "R2");
    cpu_op(0, C, 0, 0, "R2 other index");

    exp_rdy(E, A, "R13");
    @(posedge clk); #1 cpu_req = 1; cpu_we = 0; cpu_addr = A;
    snp_valid = 1; snp_cmd = RD; snp_addr = B;
    @(negedge clk);
    checks++;
    if (cpu_ready !== 1'b0) fail("R13", "hit during same-index snoop", {19'd0, cpu_ready}, 20'd0);
    @(posedge clk); #1 snp_valid = 0;
    @(negedge clk);
    checks++;
    if (cpu_ready !== 1'b1) fail("R13", "hit after snoop", {19'd0, cpu_ready}, 20'd1);
    @(posedge clk); #1 cpu_req = 0;

    exp_rdy(E, A, "R13");
    @(posedge clk); #1 cpu_req = 1; cpu_we = 0; cpu_addr = A;
    snp_valid = 1; snp_cmd = RD; snp_addr = 16'h0045;
    @(negedge clk);
    checks++;
    if (cpu_ready !== 1'b1) fail("R13", "hit beside other-index snoop", {19'd0, cpu_ready}, 20'd1);
    @(posedge clk); #1 cpu_req = 0; snp_valid = 0;

    @(negedge clk);
    checks++;
    if (cpu_ready !== 1'b0) fail("R14", "ready without request", {19'd0, cpu_ready}, 20'd0);
    repeat (2) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) fail("R12", "events left unseen", 20'(exp_q.size()), 20'd0);
    summary();
  end
endmodule